// File: doc/BRIEF.md
# Burst Refresh Scheduler

This block paces refresh traffic for a DRAM controller. A period timer counts controller clock cycles up to a programmed limit; each time the limit is reached, a programmed number of refreshes is added to a backlog counter. The backlog is offered to the memory sequencer one refresh at a time. The request line stays high while work remains, and each grant from the sequencer retires one refresh.

Both the period and the burst size live in a single 20-bit control word, written through a simple write strobe. A global enable gates the whole scheduler. Dropping the enable freezes the timer at zero and throws away any backlog. Writing the control word restarts the period from the beginning. The backlog counter saturates, so bursts that arrive faster than the sequencer drains them never wrap to a small value.

Top module: `refresh_burst_sched`

## Requirements
- R1: After reset the backlog is 0, the request is low, and the control word holds period 0x4000 and burst size 8.
- R2: With the enable high and no control write, the period timer counts 0,1,…,P (P is the period field) and then returns to 0. The backlog is raised once every P+1 cycles, with the first increase P+1 clock edges after the timer leaves 0.
- R3: The control word carries the period in bits [15:0] and the burst size (0 to 15) in bits [19:16]. On each period expiry, the burst size is added to the backlog.
- R4: The request output is high exactly when the backlog is non-zero.
- R5: A grant while the request is high lowers the backlog by one. A grant while the request is low has no effect.
- R6: The backlog saturates at 2^PEND_W-1 (63 by default) and does not wrap.
- R7: While the enable is low, the backlog is cleared on the next edge and the timer is held at 0. After re-enabling, the first expiry comes P+1 edges later.
- R8: A control write resets the timer to 0. No expiry happens on the edge where the write takes effect, and repeated writes spaced closer than P+1 cycles prevent any expiry.
- R9: A burst size of 0 produces no requests.
- R10: When an expiry and an accepted grant fall on the same edge, the backlog becomes old + burst − 1, then saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_on | input | 1 | Global refresh enable |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 20 | Control word: [19:16] burst size, [15:0] period |
| seq_grant | input | 1 | Sequencer accepts one refresh |
| refresh_req | output | 1 | A refresh is pending |
| refresh_pending | output | PEND_W (6) | Backlog of refreshes not yet granted |

## Verification
A wrong timer count shows up only at the next expiry. The backlog then changes one or more cycles early or late, so a period fault can stay hidden for up to P+1 cycles. Every such fault is caught by comparing the backlog against a reference model on every cycle. A wrong backlog update (a lost grant, a wrong burst addition, a wrap instead of a clamp) appears on `refresh_pending` on the very next edge. A stuck request becomes visible on the edge where the backlog first reaches zero.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    parameter int PERIOD_W = 16;
    parameter int BURST_W  = 4;
    localparam int CTRL_W  = PERIOD_W + BURST_W;

    typedef struct packed {
        logic [BURST_W-1:0]  burst;
        logic [PERIOD_W-1:0] period;
    } rfs_ctrl_t;

    localparam rfs_ctrl_t CTRL_RESET = '{burst: BURST_W'(8), period: PERIOD_W'(16'h4000)};
endpackage

// File: rtl/rfs_ctrl_reg.sv
module rfs_ctrl_reg
    import refresh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output rfs_ctrl_t         ctrl
);
    typedef struct packed {
        rfs_ctrl_t word;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.word = rfs_ctrl_t'(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{word: CTRL_RESET};
        else        st_q <= st_d;
    end

    assign ctrl = st_q.word;

    // R3
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl == rfs_ctrl_t'($past(wr_data)));
endmodule

// File: rtl/rfs_period_timer.sv
module rfs_period_timer
    import refresh_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                restart,
    input  logic [PERIOD_W-1:0] period,
    output logic                expire
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = enable && !restart && (st_q.cnt == period);
        if (!enable || restart) st_d.cnt = '0;
        else if (expire)        st_d.cnt = '0;
        else                    st_d.cnt = st_q.cnt + PERIOD_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.cnt == '0);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !restart && !expire) |=> st_q.cnt == $past(st_q.cnt) + PERIOD_W'(1));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> st_q.cnt == '0);
endmodule

// File: rtl/rfs_pending_ctr.sv
module rfs_pending_ctr
    import refresh_pkg::*;
#(
    parameter int PEND_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               add_pulse,
    input  logic [BURST_W-1:0] add_amt,
    input  logic               grant,
    output logic [PEND_W-1:0]  pending,
    output logic               req
);
    localparam int              SUM_W = PEND_W + 1;
    localparam logic [SUM_W-1:0] CAP  = SUM_W'((1 << PEND_W) - 1);

    typedef struct packed {
        logic [PEND_W-1:0] pend;
    } state_t;

    state_t           st_d, st_q;
    logic             take;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        take = grant && (st_q.pend != '0);
        sum  = {1'b0, st_q.pend};
        if (add_pulse) sum = sum + SUM_W'(add_amt);
        if (take)      sum = sum - SUM_W'(1);
        if (!enable)        st_d.pend = '0;
        else if (sum > CAP) st_d.pend = CAP[PEND_W-1:0];
        else                st_d.pend = sum[PEND_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;
    assign req     = (st_q.pend != '0);

    // R5
    grant_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && req && grant && !add_pulse) |=> pending == $past(pending) - PEND_W'(1));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !add_pulse && !req) |=> pending == '0);

    // R7
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> pending == '0);

    // R6
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && add_pulse && add_amt != '0 && pending == CAP[PEND_W-1:0])
            |=> pending == CAP[PEND_W-1:0]);
endmodule

// File: rtl/refresh_burst_sched.sv
module refresh_burst_sched
    import refresh_pkg::*;
#(
    parameter int PEND_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_on,
    input  logic              ctrl_wr,
    input  logic [19:0]       ctrl_wdata,
    input  logic              seq_grant,
    output logic              refresh_req,
    output logic [PEND_W-1:0] refresh_pending
);
    rfs_ctrl_t ctrl;
    logic      expire;

    rfs_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_data (CTRL_W'(ctrl_wdata)),
        .ctrl    (ctrl)
    );

    rfs_period_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (refresh_on),
        .restart (ctrl_wr),
        .period  (ctrl.period),
        .expire  (expire)
    );

    rfs_pending_ctr #(.PEND_W(PEND_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (refresh_on),
        .add_pulse (expire),
        .add_amt   (ctrl.burst),
        .grant     (seq_grant),
        .pending   (refresh_pending),
        .req       (refresh_req)
    );

    // R9
    zero_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.burst == '0 && !refresh_req) |=> !refresh_req);
endmodule

// File: tb/refresh_burst_sched_tb.sv
module refresh_burst_sched_tb;
    localparam int PW  = 6;
    localparam int CAP = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh_on = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [19:0]   ctrl_wdata = '0;
    logic          seq_grant = 1'b0;
    logic          refresh_req;
    logic [PW-1:0] refresh_pending;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    int    exp_q[$];

    always #5 clk = ~clk;

    refresh_burst_sched #(.PEND_W(PW)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .refresh_on      (refresh_on),
        .ctrl_wr         (ctrl_wr),
        .ctrl_wdata      (ctrl_wdata),
        .seq_grant       (seq_grant),
        .refresh_req     (refresh_req),
        .refresh_pending (refresh_pending)
    );

    // Reference model derived from the requirements; pushes one expected backlog per edge
    int m_cnt = 0, m_per = 16'h4000, m_bur = 8, m_pend = 0;
    always @(posedge clk) begin
        bit tick;
        bit dec;
        if (!rst_n) begin
            m_cnt = 0; m_per = 16'h4000; m_bur = 8; m_pend = 0;
        end else begin
            tick = refresh_on && !ctrl_wr && (m_cnt == m_per);
            dec  = (m_pend != 0) && seq_grant;
            if (!refresh_on) m_pend = 0;
            else begin
                m_pend = m_pend + (tick ? m_bur : 0) - (dec ? 1 : 0);
                if (m_pend > CAP) m_pend = CAP;
            end
            if (!refresh_on || ctrl_wr || tick) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (ctrl_wr) begin
                m_per = int'(ctrl_wdata[15:0]);
                m_bur = int'(ctrl_wdata[19:16]);
            end
        end
        exp_q.push_back(m_pend);
    end

    // Monitor: pops the expected backlog and compares away from the edge
    always @(negedge clk) begin
        int e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_cmp++;
            if (int'(refresh_pending) != e) begin
                n_bad++;
                $display("FAIL %s: pending=%0d expected=%0d", cur_tag, refresh_pending, e);
            end
            n_cmp++;
            if (refresh_req != (e != 0)) begin
                n_bad++;
                $display("FAIL R4: req=%0b expected=%0b", refresh_req, (e != 0));
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int exp_pend);
        n_cmp++;
        if (int'(refresh_pending) != exp_pend || refresh_req != (exp_pend != 0)) begin
            n_bad++;
            $display("FAIL %s: pending=%0d req=%0b expected pending=%0d", tag,
                     refresh_pending, refresh_req, exp_pend);
        end
    endtask

    task automatic wr_ctrl(input int burst, input int period);
        ctrl_wr    = 1'b1;
        ctrl_wdata = {4'(burst), 16'(period)};
        cyc(1);
        ctrl_wr    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", 0);

        // R1 default period and burst, R2 timing
        cur_tag = "R2";
        refresh_on = 1'b1;
        cyc(16384);
        chk("R2", 0);
        cyc(1);
        chk("R1", 8);

        // R5 drain by grants, then idle grants ignored
        cur_tag = "R5";
        seq_grant = 1'b1;
        cyc(1);
        chk("R5", 7);
        cyc(7);
        chk("R5", 0);
        cyc(3);
        chk("R5", 0);
        seq_grant = 1'b0;

        // R3 new word, R2 expiry P+1 edges after restart
        cur_tag = "R3";
        wr_ctrl(2, 3);
        cyc(3);
        chk("R2", 0);
        cyc(1);
        chk("R3", 2);

        // R10 expiry and grant on the same edge
        cur_tag = "R10";
        cyc(3);
        chk("R2", 2);
        seq_grant = 1'b1;
        cyc(1);
        seq_grant = 1'b0;
        chk("R10", 3);

        // R8 writes closer than P+1 prevent expiry
        cur_tag = "R8";
        for (int i = 0; i < 4; i++) begin
            wr_ctrl(2, 3);
            cyc(2);
        end
        chk("R8", 3);

        // R7 disable clears and holds timer
        cur_tag = "R7";
        refresh_on = 1'b0;
        cyc(1);
        chk("R7", 0);
        cyc(10);
        chk("R7", 0);
        refresh_on = 1'b1;
        cyc(3);
        chk("R7", 0);
        cyc(1);
        chk("R7", 2);

        // R9 burst size zero
        cur_tag = "R9";
        seq_grant = 1'b1;
        wr_ctrl(0, 3);
        cyc(1);
        seq_grant = 1'b0;
        chk("R5", 0);
        cyc(20);
        chk("R9", 0);

        // R6 saturation, R8 no expiry on the write edge
        cur_tag = "R6";
        wr_ctrl(15, 0);
        chk("R8", 0);
        cyc(4);
        chk("R6", 60);
        cyc(2);
        chk("R6", CAP);
        seq_grant = 1'b1;
        cyc(1);
        seq_grant = 1'b0;
        chk("R6", CAP);

        // R4 mixed grant pattern against the model
        cur_tag = "R4";
        wr_ctrl(3, 5);
        for (int i = 0; i < 120; i++) begin
            seq_grant = (i % 3) != 0;
            cyc(1);
        end
        seq_grant = 1'b0;
        cyc(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule